// File: doc/BRIEF.md
# Cross-Lane Outer Equalization Controller

This block is a host-side supervisor for a multi-lane serial link. It runs after each lane has finished its own equalization and the link carries traffic. It asks a margining engine to measure the eye margin of every lane. It then sorts the lanes into margin-starved lanes, donor lanes that have margin to spare, and lanes in between. When starved lanes exist, it tells the donor lanes to back off one transmitter parameter. It re-measures after each command and repeats until no lane is starved.

Transmitter parameters are tried in a fixed order. Edge rate is slowed first, then launch amplitude is lowered, then de-emphasis is reduced. The controller moves on to the next parameter when the current one has used its programmed number of steps or has no donor left. A donor whose margin falls to the starved level after an adjustment is stepped back by the same amount. It is then barred from donating for the rest of that parameter. The run ends with a pass or fail status that stays visible until the next start.

Top module: `oeq_ctrl`

## Requirements
- R1: A start pulse while idle or finished loads the configuration and raises `meas_req`. `meas_req` stays high until `meas_done`, and all lane margins are captured in the `meas_done` cycle.
- R2: If no lane is starved after a measurement, the run ends with `done`=1 and `pass`=1, and no further command is issued.
- R3: A lane is starved when its margin is strictly below the low threshold. It is a donor candidate when its margin is strictly above the high threshold. A margin equal to either threshold is neither.
- R4: When starved lanes exist and the current parameter still has steps and eligible donors, one command is issued. Its lane mask is the donor candidates not barred, `cmd_up`=0 (reduce), and `cmd_amt` is the configured step.
- R5: Parameter codes on `cmd_param` are 0 for edge rate, 1 for amplitude and 2 for de-emphasis, used in that order. The controller advances to the next code when the current one has issued `iter_limit` reductions or has no eligible donor. Advancing clears the step count and the barred set.
- R6: After a reduction, any targeted lane that is now starved gets a revert command. The revert uses the same parameter and amount with `cmd_up`=1, addresses only those lanes, and bars them for the rest of that parameter.
- R7: When the de-emphasis parameter (code 2) must advance, the run ends with `done`=1 and `pass`=0.
- R8: `cmd_valid` and `meas_req` are never high together. A command and its fields hold until `cmd_done`, after which a new measurement is requested.
- R9: Threshold, limit and step inputs are used only as latched at start. Changing them during a run has no effect on the run.
- R10: After reset, and once a run ends, `busy`, `cmd_valid` and `meas_req` are low. `done` and `pass` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a balancing run |
| thr_low | input | MW | Starved-lane threshold |
| thr_high | input | MW | Donor threshold |
| iter_limit | input | ITW | Reductions allowed per parameter |
| step_amt | input | AW | Amount carried by each command |
| meas_req | output | 1 | Request to margin all lanes |
| meas_done | input | 1 | Margin results valid on `lane_margin` |
| lane_margin | input | NL*MW | Per-lane margin, lane i at bits i*MW upward |
| cmd_valid | output | 1 | Transmitter command pending |
| cmd_lanes | output | NL | Lanes addressed by the command |
| cmd_param | output | 2 | Parameter code (0 edge rate, 1 amplitude, 2 de-emphasis) |
| cmd_up | output | 1 | 1 increase, 0 decrease |
| cmd_amt | output | AW | Command amount |
| cmd_done | input | 1 | Command applied at both ends of the lanes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished run balanced the lanes |

## Verification
Several properties are checked on every cycle:
- the exclusion between a command and a measurement request;
- command fields held while a command waits;
- reductions addressing only lanes that measured above the high threshold, and reverts only lanes below the low one;
- the per-parameter step count staying within its limit;
- parameter codes moving up by exactly one;
- the latched configuration staying frozen during a run.

Other behaviours only the scenarios can show, because they depend on a whole sequence of measurements, against a reference model in the bench:
- the exact donor set after earlier reverts;
- the point at which a parameter is given up;
- the pass or fail verdict;
- the threshold boundaries.

// File: rtl/oeq_pkg.sv
package oeq_pkg;

  typedef enum logic [1:0] {
    P_SLEW   = 2'd0,
    P_AMP    = 2'd1,
    P_DEEMPH = 2'd2
  } txparam_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MEAS = 3'd1,
    S_EVAL = 3'd2,
    S_CMD  = 3'd3,
    S_FIN  = 3'd4
  } oeq_state_e;

  function automatic txparam_e next_param(input txparam_e p);
    case (p)
      P_SLEW:  return P_AMP;
      P_AMP:   return P_DEEMPH;
      default: return P_DEEMPH;
    endcase
  endfunction

  function automatic logic is_final_param(input txparam_e p);
    return p == P_DEEMPH;
  endfunction

  // Every parameter is traded away by reducing it; a revert goes the other way.
  function automatic logic reduce_dir(input txparam_e p);
    return (p == P_SLEW) ? 1'b0 : 1'b0;
  endfunction

endpackage

// File: rtl/oeq_lane_class.sv
module oeq_lane_class #(
  parameter int NL = 4,
  parameter int MW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL*MW-1:0] margins,
  input  logic [MW-1:0]    thr_lo,
  input  logic [MW-1:0]    thr_hi,
  output logic [NL-1:0]    low_mask,
  output logic [NL-1:0]    high_mask
);

  function automatic logic below(input logic [MW-1:0] m, input logic [MW-1:0] t);
    return m < t;
  endfunction

  function automatic logic above(input logic [MW-1:0] m, input logic [MW-1:0] t);
    return m > t;
  endfunction

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [MW-1:0] m;
    assign m            = margins[g*MW +: MW];
    assign low_mask[g]  = below(m, thr_lo);
    assign high_mask[g] = above(m, thr_hi);
  end

  // R3: with ordered thresholds no lane is both starved and a donor
  p_class_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hi >= thr_lo) |-> ((low_mask & high_mask) == '0));

endmodule

// File: rtl/oeq_param_track.sv
module oeq_param_track
  import oeq_pkg::*;
#(
  parameter int ITW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           advance,
  input  logic           bump,
  input  logic [ITW-1:0] limit,
  output txparam_e       param,
  output logic           exhausted,
  output logic           last_param
);

  logic [ITW-1:0] iter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      param <= P_SLEW;
      iter  <= '0;
    end else if (clear) begin
      param <= P_SLEW;
      iter  <= '0;
    end else if (advance) begin
      param <= next_param(param);
      iter  <= '0;
    end else if (bump) begin
      iter  <= iter + 1'b1;
    end
  end

  assign exhausted  = iter >= limit;
  assign last_param = is_final_param(param);

  // R5: step count never passes the programmed limit
  p_iter_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iter <= limit);

  // R5: parameters move forward one code at a time
  p_param_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && advance) |=> (param == next_param($past(param))) && (iter == '0));

  p_param_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(param));

endmodule

// File: rtl/oeq_ctrl.sv
module oeq_ctrl
  import oeq_pkg::*;
#(
  parameter int NL  = 4,
  parameter int MW  = 8,
  parameter int ITW = 4,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MW-1:0]    thr_low,
  input  logic [MW-1:0]    thr_high,
  input  logic [ITW-1:0]   iter_limit,
  input  logic [AW-1:0]    step_amt,
  output logic             meas_req,
  input  logic             meas_done,
  input  logic [NL*MW-1:0] lane_margin,
  output logic             cmd_valid,
  output logic [NL-1:0]    cmd_lanes,
  output logic [1:0]       cmd_param,
  output logic             cmd_up,
  output logic [AW-1:0]    cmd_amt,
  input  logic             cmd_done,
  output logic             busy,
  output logic             done,
  output logic             pass
);

  oeq_state_e state;

  logic [NL*MW-1:0] marg_q;
  logic [MW-1:0]    cfg_lo, cfg_hi;
  logic [ITW-1:0]   cfg_lim;
  logic [AW-1:0]    cfg_amt;
  logic [NL-1:0]    excl, last_lanes;
  logic             last_adj;
  logic [NL-1:0]    lanes_q;
  txparam_e         param_q;
  logic             up_q, pass_q;

  logic [NL-1:0] low_mask, high_mask, fell, elig;
  logic          load, step_out;
  logic          ev_revert, ev_pass, ev_adv, ev_fail, ev_adj;
  txparam_e      param;
  logic          exhausted, last_param;

  oeq_lane_class #(.NL(NL), .MW(MW)) u_class (
    .clk       (clk),
    .rst_n     (rst_n),
    .margins   (marg_q),
    .thr_lo    (cfg_lo),
    .thr_hi    (cfg_hi),
    .low_mask  (low_mask),
    .high_mask (high_mask)
  );

  oeq_param_track #(.ITW(ITW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (load),
    .advance    (ev_adv),
    .bump       (ev_adj),
    .limit      (cfg_lim),
    .param      (param),
    .exhausted  (exhausted),
    .last_param (last_param)
  );

  // Decision taken in the evaluation cycle, in priority order
  assign load      = start && (state == S_IDLE || state == S_FIN);
  assign fell      = last_adj ? (last_lanes & low_mask) : '0;
  assign elig      = high_mask & ~excl;
  assign step_out  = (elig == '0) || exhausted;
  assign ev_revert = (state == S_EVAL) && (fell != '0);
  assign ev_pass   = (state == S_EVAL) && (fell == '0) && (low_mask == '0);
  assign ev_adv    = (state == S_EVAL) && (fell == '0) && (low_mask != '0) && step_out && !last_param;
  assign ev_fail   = (state == S_EVAL) && (fell == '0) && (low_mask != '0) && step_out && last_param;
  assign ev_adj    = (state == S_EVAL) && (fell == '0) && (low_mask != '0) && !step_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      marg_q     <= '0;
      cfg_lo     <= '0;
      cfg_hi     <= '0;
      cfg_lim    <= '0;
      cfg_amt    <= '0;
      excl       <= '0;
      last_lanes <= '0;
      last_adj   <= 1'b0;
      lanes_q    <= '0;
      param_q    <= P_SLEW;
      up_q       <= 1'b0;
      pass_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (load) begin
            cfg_lo   <= thr_low;
            cfg_hi   <= thr_high;
            cfg_lim  <= iter_limit;
            cfg_amt  <= step_amt;
            excl     <= '0;
            last_adj <= 1'b0;
            pass_q   <= 1'b0;
            state    <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (meas_done) begin
            marg_q <= lane_margin;
            state  <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (ev_revert) begin
            lanes_q  <= fell;
            param_q  <= param;
            up_q     <= ~reduce_dir(param);
            excl     <= excl | fell;
            last_adj <= 1'b0;
            state    <= S_CMD;
          end else if (ev_pass) begin
            pass_q <= 1'b1;
            state  <= S_FIN;
          end else if (ev_fail) begin
            pass_q <= 1'b0;
            state  <= S_FIN;
          end else if (ev_adv) begin
            excl     <= '0;
            last_adj <= 1'b0;
          end else if (ev_adj) begin
            lanes_q    <= elig;
            param_q    <= param;
            up_q       <= reduce_dir(param);
            last_lanes <= elig;
            last_adj   <= 1'b1;
            state      <= S_CMD;
          end
        end
        S_CMD: begin
          if (cmd_done) state <= S_MEAS;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign meas_req  = (state == S_MEAS);
  assign cmd_valid = (state == S_CMD);
  assign cmd_lanes = lanes_q;
  assign cmd_param = param_q;
  assign cmd_up    = up_q;
  assign cmd_amt   = cfg_amt;
  assign busy      = (state == S_MEAS) || (state == S_EVAL) || (state == S_CMD);
  assign done      = (state == S_FIN);
  assign pass      = pass_q;

  // R8: a command and a measurement request are never pending together
  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && meas_req));

  // R8: a waiting command holds its fields
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> cmd_valid && $stable(cmd_lanes) && $stable(cmd_param)
                                 && $stable(cmd_up) && $stable(cmd_amt));

  // R8: completion of a command leads to a new measurement
  p_cmd_then_meas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=> meas_req);

  // R4: reductions address only measured donors, and at least one lane
  p_donor_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_up) |-> ((cmd_lanes & ~high_mask) == '0) && (cmd_lanes != '0));

  // R6: reverts address only lanes now starved
  p_revert_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_up) |-> ((cmd_lanes & ~low_mask) == '0) && (cmd_lanes != '0));

  // R2: a passing verdict means no lane was starved in the last measurement
  p_pass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (low_mask == '0));

  // R9: latched configuration is frozen during a run
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_lo) && $stable(cfg_hi) && $stable(cfg_lim) && $stable(cfg_amt));

  // R10: final state holds until a new start
  p_fin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(pass));

endmodule

// File: tb/sim_oeq_ctrl.sv
module sim_oeq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int MW = 8;

  logic        clk = 1'b0;
  logic        rst_n, start, meas_done, cmd_done;
  logic [7:0]  thr_low, thr_high;
  logic [3:0]  iter_limit, step_amt;
  logic [31:0] lane_margin;
  logic        meas_req, cmd_valid, cmd_up, busy, done, pass;
  logic [3:0]  cmd_lanes, cmd_amt;
  logic [1:0]  cmd_param;

  always #(CLK_PERIOD/2) clk = ~clk;

  oeq_ctrl #(.NL(NL), .MW(MW), .ITW(4), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .thr_low(thr_low), .thr_high(thr_high), .iter_limit(iter_limit), .step_amt(step_amt),
    .meas_req(meas_req), .meas_done(meas_done), .lane_margin(lane_margin),
    .cmd_valid(cmd_valid), .cmd_lanes(cmd_lanes), .cmd_param(cmd_param),
    .cmd_up(cmd_up), .cmd_amt(cmd_amt), .cmd_done(cmd_done),
    .busy(busy), .done(done), .pass(pass)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench reference model state
  int         c_lo, c_hi, c_lim, c_amt;
  int         r_par, r_iter;
  logic [3:0] r_excl, r_last;
  bit         r_adj;
  logic [7:0] cur_m [0:3];
  logic [7:0] scr [0:7][0:3];

  function automatic logic [3:0] starved_set();
    logic [3:0] s;
    for (int l = 0; l < NL; l++) s[l] = (int'(cur_m[l]) < c_lo);
    return s;
  endfunction

  function automatic logic [3:0] donor_set();
    logic [3:0] s;
    for (int l = 0; l < NL; l++) s[l] = (int'(cur_m[l]) > c_hi);
    return s;
  endfunction

  // kind: 0 command, 1 pass, 2 fail
  task automatic ref_next(output int kind, output logic [3:0] lanes, output int par, output bit up);
    logic [3:0] lo_s, hi_s, fell, el;
    lo_s = starved_set();
    hi_s = donor_set();
    fell = r_adj ? (r_last & lo_s) : 4'b0;
    r_adj = 1'b0;
    kind = 2; lanes = '0; par = r_par; up = 1'b0;
    if (fell != 0) begin
      kind = 0; lanes = fell; par = r_par; up = 1'b1;
      r_excl = r_excl | fell;
      return;
    end
    if (lo_s == 0) begin
      kind = 1;
      return;
    end
    for (int k = 0; k < 4; k++) begin
      el = hi_s & ~r_excl;
      if (el == 0 || r_iter >= c_lim) begin
        if (r_par == 2) begin
          kind = 2;
          return;
        end
        r_par++; r_iter = 0; r_excl = '0;
      end else begin
        kind = 0; lanes = el; par = r_par; up = 1'b0;
        r_iter++; r_adj = 1'b1; r_last = el;
        return;
      end
    end
  endtask

  task automatic run(input int lo, input int hi, input int lim, input int amt, input bit scripted);
    int kind, par;
    logic [3:0] lanes;
    bit up, seen;
    @(negedge clk);
    thr_low = lo[7:0]; thr_high = hi[7:0]; iter_limit = lim[3:0]; step_amt = amt[3:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c_lo = lo; c_hi = hi; c_lim = lim; c_amt = amt;
    r_par = 0; r_iter = 0; r_excl = '0; r_last = '0; r_adj = 1'b0;
    for (int st = 0; st < 64; st++) begin
      seen = 1'b0;
      for (int w = 0; w < 20 && !seen; w++) begin
        if (meas_req) seen = 1'b1; else @(negedge clk);
      end
      chk("R1 meas_req raised", int'(meas_req), 1);
      if (!seen) return;
      chk("R1 busy during run", int'(busy), 1);
      for (int l = 0; l < NL; l++) begin
        cur_m[l] = scripted ? scr[st][l] : 8'($urandom_range(0, 255));
        lane_margin[l*8 +: 8] = cur_m[l];
      end
      meas_done = 1'b1;
      @(negedge clk);
      meas_done = 1'b0;
      lane_margin = $urandom();
      // R9: scramble configuration inputs mid-run
      thr_low = 8'($urandom()); thr_high = 8'($urandom());
      iter_limit = 4'($urandom()); step_amt = 4'($urandom());
      ref_next(kind, lanes, par, up);
      seen = 1'b0;
      for (int w = 0; w < 20 && !seen; w++) begin
        if (cmd_valid || done) seen = 1'b1; else @(negedge clk);
      end
      if (kind == 0) begin
        chk(up ? "R6 revert issued" : "R4 command issued", int'(cmd_valid), 1);
        chk(up ? "R6 revert lanes" : "R4 donor lanes", int'(cmd_lanes), int'(lanes));
        chk("R5 parameter code", int'(cmd_param), par);
        chk(up ? "R6 direction" : "R4 direction", int'(cmd_up), int'(up));
        chk("R9 latched amount", int'(cmd_amt), c_amt);
        chk("R8 no request during command", int'(meas_req), 0);
        if (!cmd_valid) return;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk("R8 command held", int'(cmd_valid), 1);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
      end else begin
        chk(kind == 1 ? "R2 finished" : "R7 finished", int'(done), 1);
        chk(kind == 1 ? "R2 pass" : "R7 fail verdict", int'(pass), kind == 1 ? 1 : 0);
        chk("R10 idle outputs at end", int'({busy, cmd_valid, meas_req}), 0);
        repeat (3) @(negedge clk);
        chk("R10 verdict held", int'({done, pass}), kind == 1 ? 3 : 2);
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    rst_n = 1'b0; start = 1'b0; meas_done = 1'b0; cmd_done = 1'b0;
    thr_low = '0; thr_high = '0; iter_limit = '0; step_amt = '0; lane_margin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset state", int'({busy, done, pass, cmd_valid, meas_req}), 0);

    // R2 R3: lane at exactly the low threshold is not starved
    scr[0] = '{8'd100, 8'd60, 8'd200, 8'd90};
    run(60, 180, 2, 3, 1'b1);

    // R3 R4: lane at exactly the high threshold is not a donor
    scr[0] = '{8'd180, 8'd20, 8'd181, 8'd100};
    scr[1] = '{8'd180, 8'd70, 8'd150, 8'd100};
    run(60, 180, 2, 5, 1'b1);

    // R6 R5: revert, barred lane, then limit forces amplitude
    scr[0] = '{8'd200, 8'd20, 8'd200, 8'd100};
    scr[1] = '{8'd200, 8'd30, 8'd40, 8'd100};
    scr[2] = '{8'd200, 8'd30, 8'd70, 8'd100};
    scr[3] = '{8'd190, 8'd30, 8'd100, 8'd100};
    scr[4] = '{8'd190, 8'd100, 8'd100, 8'd100};
    run(60, 180, 2, 7, 1'b1);

    // R7: zero limit exhausts every parameter at once
    scr[0] = '{8'd200, 8'd20, 8'd100, 8'd100};
    run(60, 180, 0, 1, 1'b1);

    // R7 R5: no donor anywhere
    scr[0] = '{8'd100, 8'd20, 8'd100, 8'd100};
    run(60, 180, 3, 1, 1'b1);

    for (int n = 0; n < 60; n++) begin
      int lo, hi;
      lo = $urandom_range(30, 110);
      hi = lo + $urandom_range(1, 100);
      run(lo, hi, $urandom_range(0, 3), $urandom_range(0, 15), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule